// File: doc/BRIEF.md
# Mode-Aware Ripple Threshold Detector

This block watches one supply rail through three digitized measurements: a per-sample peak-to-peak ripple value, a windowed RMS ripple value and the rail level itself. It raises a transient alert when the peak-to-peak value stays too high. It raises a continuous alert when the RMS value stays too high. It raises an overvoltage alert when the rail level goes above its limit. Three setpoint sets are held on input ports:

- one for fixed-frequency PWM operation,
- one for light-load pulse-frequency operation, where the peak limits are relaxed,
- one for startup or crank.

Each set gives a peak limit, an RMS limit and a hysteresis gap. The gap places the release level below the assertion level.

An alert qualifies in one of two ways. Either enough samples exceed the limit inside a voting window, or a single exceedance persists for a debounce time with no clean sample after it. Both windows are counted in ticks of a shared timebase strobe, so they do not depend on the sample rate.

The startup/crank input suppresses the ripple alerts while it is active. After it falls, the startup setpoints stay in force for a hold-off time. The overvoltage path is never masked and needs no voting. Every qualified rising edge of an alert produces a one-cycle event strobe together with a cause code.

Top module: `ripple_mode_detector`

## Requirements
- R1: The transient alert sets when `N_VOTES` (default 3) samples with `vpp_i` strictly above the active peak limit are counted without an intervening window expiry. It becomes visible one cycle after the qualifying sample.
- R2: The continuous alert qualifies in the same way as R1, using `rms_i` against the active RMS limit. Its vote counter is independent of the transient one.
- R3: A sample above the limit arms a persistence count. Each following tick advances that count, and any sample at or below the limit resets it. When `DEB_TICKS` (default 3) ticks are reached, the alert sets even with fewer than `N_VOTES` votes.
- R4: Every `WIN_TICKS` (default 4) ticks the voting window expires and clears the accumulated votes.
- R5: An active ripple alert clears on a sample strictly below (limit − gap), where that difference saturates at zero. A release also clears the votes, the persistence count and the window count.
- R6: With no startup condition, `mode_i`=0 selects the PWM setpoints and `mode_i`=1 selects the pulse-frequency setpoints. The selection applies to both assertion and release.
- R7: While `mask_i`=1, both ripple alerts are forced low and no votes accumulate. The startup setpoints apply while `mask_i`=1 and for `HOLD_TICKS` (default 3) ticks after it falls.
- R8: Any change of the selected setpoint set clears the vote, persistence and window counters. The sample arriving in that cycle is counted under the new set. An alert that is already active is kept.
- R9: A sample with `lvl_i` above `ov_lim_i` sets the overvoltage alert one cycle later, regardless of `mask_i`. A sample with `lvl_i` at or below the limit clears it.
- R10: `event_o` is high for exactly the cycle in which an alert first shows high. `cause_o` reads 2'b11 for overvoltage, 2'b01 for transient and 2'b10 for continuous, in that priority order, and 2'b00 when there is no event.
- R11: During reset, and in the first cycle after it, all alerts, `event_o` and `cause_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = PWM operation, 1 = pulse-frequency operation |
| mask_i | input | 1 | Startup/crank indication |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| smp_valid_i | input | 1 | The sample inputs hold a new set of values |
| vpp_i | input | W | Peak-to-peak ripple sample |
| rms_i | input | W | Windowed RMS ripple sample |
| lvl_i | input | W | Rail level sample |
| tr_lim_pwm_i | input | W | Peak limit, PWM |
| tr_lim_pfm_i | input | W | Peak limit, pulse-frequency |
| tr_lim_start_i | input | W | Peak limit, startup |
| ct_lim_pwm_i | input | W | RMS limit, PWM |
| ct_lim_pfm_i | input | W | RMS limit, pulse-frequency |
| ct_lim_start_i | input | W | RMS limit, startup |
| gap_pwm_i | input | W | Hysteresis gap, PWM |
| gap_pfm_i | input | W | Hysteresis gap, pulse-frequency |
| gap_start_i | input | W | Hysteresis gap, startup |
| ov_lim_i | input | W | Overvoltage limit |
| tr_alert_o | output | 1 | Transient alert |
| ct_alert_o | output | 1 | Continuous alert |
| ov_alert_o | output | 1 | Overvoltage alert |
| event_o | output | 1 | Qualified assertion strobe |
| cause_o | output | 2 | Cause of the current event |

## Verification
The assertions take several things for granted:

- `tick_i` is a single-cycle strobe.
- `mode_i` and `mask_i` are synchronous to `clk`.
- Setpoints only change while the block is in reset or idle.

The stimulus changes the setpoint ports only after a reset. Apart from the mode and mask transitions it exercises on purpose, it holds the mode and mask inputs steady. It also keeps samples and ticks in separate cycles, so each expected value follows from one rule at a time. The rules in play are voting, persistence, window expiry, hold-off countdown and set change.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
    typedef enum logic [1:0] {
        SET_PWM   = 2'd0,
        SET_PFM   = 2'd1,
        SET_START = 2'd2
    } set_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_TRANS = 2'b01,
        CAUSE_CONT  = 2'b10,
        CAUSE_OV    = 2'b11
    } cause_e;
endpackage

// File: rtl/rrd_set_sel.sv
module rrd_set_sel
    import rrd_pkg::*;
#(
    parameter int HOLD_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic mask_i,
    input  logic tick_i,
    output set_e set_o,
    output logic chg_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
        set_e          set;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (mask_i) begin
            d.hold = HW'(HOLD_TICKS);
        end else if (tick_i && q.hold != '0) begin
            d.hold = q.hold - 1'b1;
        end
        if (mask_i || q.hold != '0) begin
            set_o = SET_START;
        end else if (mode_i) begin
            set_o = SET_PFM;
        end else begin
            set_o = SET_PWM;
        end
        d.set = set_o;
        chg_o = (set_o != q.set);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{hold: '0, set: SET_PWM};
        end else begin
            q <= d;
        end
    end

    // R7
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mask_i) |-> (set_o == SET_START));
endmodule

// File: rtl/rrd_metric_qual.sv
module rrd_metric_qual #(
    parameter int W         = 12,
    parameter int N_VOTES   = 3,
    parameter int WIN_TICKS = 4,
    parameter int DEB_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         tick_i,
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lim_i,
    input  logic [W-1:0] gap_i,
    input  logic         clr_i,
    input  logic         sup_i,
    output logic         alert_o,
    output logic         rise_o
);
    localparam int VW = $clog2(N_VOTES + 1);
    localparam int TW = $clog2(WIN_TICKS + 1);
    localparam int PW = $clog2(DEB_TICKS + 1);

    typedef struct packed {
        logic [VW-1:0] votes;
        logic [TW-1:0] win;
        logic [PW-1:0] pers;
        logic          over;
        logic          alert;
        logic          rise;
    } st_t;

    st_t q, d;
    logic [W-1:0] rel;

    always_comb begin
        d      = q;
        d.rise = 1'b0;
        rel    = (lim_i > gap_i) ? (lim_i - gap_i) : '0;
        if (sup_i) begin
            d = '0;
        end else begin
            if (clr_i) begin
                d.votes = '0;
                d.win   = '0;
                d.pers  = '0;
                d.over  = 1'b0;
            end
            if (tick_i) begin
                if (d.win == TW'(WIN_TICKS - 1)) begin
                    d.win   = '0;
                    d.votes = '0;
                end else begin
                    d.win = d.win + 1'b1;
                end
                if (d.over && d.pers != PW'(DEB_TICKS)) begin
                    d.pers = d.pers + 1'b1;
                end
            end
            if (valid_i) begin
                if (val_i > lim_i) begin
                    d.over = 1'b1;
                    if (d.votes != VW'(N_VOTES)) begin
                        d.votes = d.votes + 1'b1;
                    end
                end else begin
                    d.over = 1'b0;
                    d.pers = '0;
                end
            end
            if (!q.alert) begin
                if (d.votes == VW'(N_VOTES) || d.pers == PW'(DEB_TICKS)) begin
                    d.alert = 1'b1;
                    d.rise  = 1'b1;
                end
            end else if (valid_i && val_i < rel) begin
                d.alert = 1'b0;
                d.votes = '0;
                d.win   = '0;
                d.pers  = '0;
                d.over  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign alert_o = q.alert;
    assign rise_o  = q.rise;

    // R7
    sup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_i |=> !alert_o);

    // R1
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_o) |-> $past(valid_i || tick_i));

    // R5
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_o) |-> $past(valid_i || sup_i));
endmodule

// File: rtl/ripple_mode_detector.sv
module ripple_mode_detector
    import rrd_pkg::*;
#(
    parameter int W          = 12,
    parameter int N_VOTES    = 3,
    parameter int WIN_TICKS  = 4,
    parameter int DEB_TICKS  = 3,
    parameter int HOLD_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         mask_i,
    input  logic         tick_i,
    input  logic         smp_valid_i,
    input  logic [W-1:0] vpp_i,
    input  logic [W-1:0] rms_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] tr_lim_pwm_i,
    input  logic [W-1:0] tr_lim_pfm_i,
    input  logic [W-1:0] tr_lim_start_i,
    input  logic [W-1:0] ct_lim_pwm_i,
    input  logic [W-1:0] ct_lim_pfm_i,
    input  logic [W-1:0] ct_lim_start_i,
    input  logic [W-1:0] gap_pwm_i,
    input  logic [W-1:0] gap_pfm_i,
    input  logic [W-1:0] gap_start_i,
    input  logic [W-1:0] ov_lim_i,
    output logic         tr_alert_o,
    output logic         ct_alert_o,
    output logic         ov_alert_o,
    output logic         event_o,
    output logic [1:0]   cause_o
);
    localparam int NM = 2;

    set_e         set_sel;
    logic         set_chg;
    logic [W-1:0] val_a   [NM];
    logic [W-1:0] lim_a   [NM];
    logic [W-1:0] gap_sel;
    logic [NM-1:0] alert_a;
    logic [NM-1:0] rise_a;

    rrd_set_sel #(.HOLD_TICKS(HOLD_TICKS)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .mask_i (mask_i),
        .tick_i (tick_i),
        .set_o  (set_sel),
        .chg_o  (set_chg)
    );

    always_comb begin
        val_a[0] = vpp_i;
        val_a[1] = rms_i;
        case (set_sel)
            SET_PFM: begin
                lim_a[0] = tr_lim_pfm_i;
                lim_a[1] = ct_lim_pfm_i;
                gap_sel  = gap_pfm_i;
            end
            SET_START: begin
                lim_a[0] = tr_lim_start_i;
                lim_a[1] = ct_lim_start_i;
                gap_sel  = gap_start_i;
            end
            default: begin
                lim_a[0] = tr_lim_pwm_i;
                lim_a[1] = ct_lim_pwm_i;
                gap_sel  = gap_pwm_i;
            end
        endcase
    end

    for (genvar g = 0; g < NM; g++) begin : g_metric
        rrd_metric_qual #(
            .W         (W),
            .N_VOTES   (N_VOTES),
            .WIN_TICKS (WIN_TICKS),
            .DEB_TICKS (DEB_TICKS)
        ) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (smp_valid_i),
            .tick_i  (tick_i),
            .val_i   (val_a[g]),
            .lim_i   (lim_a[g]),
            .gap_i   (gap_sel),
            .clr_i   (set_chg),
            .sup_i   (mask_i),
            .alert_o (alert_a[g]),
            .rise_o  (rise_a[g])
        );
    end

    typedef struct packed {
        logic alert;
        logic rise;
    } ov_t;

    ov_t ov_q, ov_d;

    always_comb begin
        ov_d      = ov_q;
        ov_d.rise = 1'b0;
        if (smp_valid_i) begin
            if (lvl_i > ov_lim_i) begin
                if (!ov_q.alert) begin
                    ov_d.rise = 1'b1;
                end
                ov_d.alert = 1'b1;
            end else begin
                ov_d.alert = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ov_d;
        end
    end

    cause_e cause_c;
    always_comb begin
        if (ov_q.rise) begin
            cause_c = CAUSE_OV;
        end else if (rise_a[0]) begin
            cause_c = CAUSE_TRANS;
        end else if (rise_a[1]) begin
            cause_c = CAUSE_CONT;
        end else begin
            cause_c = CAUSE_NONE;
        end
    end

    assign tr_alert_o = alert_a[0];
    assign ct_alert_o = alert_a[1];
    assign ov_alert_o = ov_q.alert;
    assign event_o    = ov_q.rise | (|rise_a);
    assign cause_o    = cause_c;

    // R9
    ov_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && lvl_i > ov_lim_i) |=> ov_alert_o);

    // R10
    ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_alert_o) |-> (event_o && cause_o == 2'b11));

    // R10
    evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> ($rose(tr_alert_o) || $rose(ct_alert_o) || $rose(ov_alert_o)));
endmodule

// File: tb/sim_ripple_mode_detector.sv
`timescale 1ns/1ps
module sim_ripple_mode_detector;
    localparam int W = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, mode, mask, tick, valid;
    logic [W-1:0] vpp, rms, lvl;
    logic [W-1:0] trp, trf, trs, ctp, ctf, cts, gp, gf, gs, ovl;
    logic tr, ct, ov, evt;
    logic [1:0] cause;

    ripple_mode_detector u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .mask_i(mask), .tick_i(tick),
        .smp_valid_i(valid), .vpp_i(vpp), .rms_i(rms), .lvl_i(lvl),
        .tr_lim_pwm_i(trp), .tr_lim_pfm_i(trf), .tr_lim_start_i(trs),
        .ct_lim_pwm_i(ctp), .ct_lim_pfm_i(ctf), .ct_lim_start_i(cts),
        .gap_pwm_i(gp), .gap_pfm_i(gf), .gap_start_i(gs), .ov_lim_i(ovl),
        .tr_alert_o(tr), .ct_alert_o(ct), .ov_alert_o(ov),
        .event_o(evt), .cause_o(cause)
    );

    typedef struct packed {
        logic m, k, v, t;
        logic [11:0] vpp, rms, lvl;
        logic etr, ect, eov, eevt;
        logic [1:0] ec;
        logic [3:0] req;
    } vec_t;

    // fields: mode mask valid tick vpp rms lvl | tr ct ov evt cause | requirement
    localparam vec_t VEC [49] = '{
        // R1 transient votes in PWM (limit 100, release below 80)
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 1},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 1},
        '{0,0,1,0,120,10,100, 1,0,0,1,1, 1},
        // R10 strobe lasts one cycle
        '{0,0,0,0,  0, 0,100, 1,0,0,0,0,10},
        // R5 inside band holds, below band releases
        '{0,0,1,0, 90,10,100, 1,0,0,0,0, 5},
        '{0,0,1,0, 70,10,100, 0,0,0,0,0, 5},
        // R4 window expiry drops stale votes
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 4},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 4},
        '{0,0,1,0, 50,10,100, 0,0,0,0,0, 4},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 4},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 4},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 4},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 4},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 4},
        // R3 persistence over ticks
        '{0,0,1,0, 50,10,100, 0,0,0,0,0, 3},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 3},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 3},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 3},
        '{0,0,0,1,  0,10,100, 1,0,0,1,1, 3},
        '{0,0,1,0, 60,10,100, 0,0,0,0,0, 5},
        // R2 continuous votes (limit 50)
        '{0,0,1,0, 10,60,100, 0,0,0,0,0, 2},
        '{0,0,1,0, 10,70,100, 0,0,0,0,0, 2},
        '{0,0,1,0, 10,55,100, 0,1,0,1,2, 2},
        // R7 mask suppresses, R9 overvoltage stays live
        '{0,1,0,0,  0, 0,100, 0,0,0,0,0, 7},
        '{0,1,1,0, 10,10,950, 0,0,1,1,3, 9},
        '{0,1,1,0, 10,10,800, 0,0,0,0,0, 9},
        '{0,1,1,0,500,500,100,0,0,0,0,0, 7},
        '{0,1,1,0,500,500,100,0,0,0,0,0, 7},
        '{0,1,1,0,500,500,100,0,0,0,0,0, 7},
        // R7 hold-off uses startup limit 300, release below 240
        '{0,0,1,0,250,10,100, 0,0,0,0,0, 7},
        '{0,0,1,0,350,10,100, 0,0,0,0,0, 7},
        '{0,0,1,0,350,10,100, 0,0,0,0,0, 7},
        '{0,0,1,0,350,10,100, 1,0,0,1,1, 7},
        '{0,0,1,0,230,10,100, 0,0,0,0,0, 5},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 7},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 7},
        '{0,0,0,1,  0,10,100, 0,0,0,0,0, 7},
        // R6 back on PWM set
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 6},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 6},
        // R8 mode changes clear votes
        '{1,0,1,0,150,10,100, 0,0,0,0,0, 8},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 8},
        '{0,0,1,0,150,10,100, 0,0,0,0,0, 8},
        '{0,0,1,0,150,10,100, 1,0,0,1,1, 8},
        // R6 PFM release band (200-30=170)
        '{1,0,1,0,190,10,100, 1,0,0,0,0, 6},
        '{1,0,1,0,160,10,100, 0,0,0,0,0, 6},
        // R10 priority
        '{0,0,1,0,150,60,100, 0,0,0,0,0,10},
        '{0,0,1,0,150,60,100, 0,0,0,0,0,10},
        '{0,0,1,0,150,60,100, 1,1,0,1,1,10},
        '{0,0,1,0,150,60,950, 1,1,1,1,3,10}
    };

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input logic [5:0] exp, input int req, input int idx);
        logic [5:0] got;
        got = {tr, ct, ov, evt, cause};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL step %0d R%0d got tr/ct/ov/evt/cause=%b expected %b", idx, req, got, exp);
        end
    endtask

    task automatic drive(input logic m, k, v, t, input logic [W-1:0] a, b, c);
        @(negedge clk);
        mode = m; mask = k; valid = v; tick = t; vpp = a; rms = b; lvl = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0; tick = 1'b0; mode = 1'b0; mask = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; mode = 0; mask = 0; tick = 0; valid = 0;
        vpp = '0; rms = '0; lvl = '0;
        trp = 100; trf = 200; trs = 300;
        ctp = 50;  ctf = 80;  cts = 150;
        gp  = 20;  gf  = 30;  gs  = 60;
        ovl = 900;
        repeat (3) @(posedge clk);
        #1;
        check(6'b0, 11, -1);            // R11 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(6'b0, 11, -2);            // R11 first cycle after reset

        for (int i = 0; i < 49; i++) begin
            drive(VEC[i].m, VEC[i].k, VEC[i].v, VEC[i].t, VEC[i].vpp, VEC[i].rms, VEC[i].lvl);
            check({VEC[i].etr, VEC[i].ect, VEC[i].eov, VEC[i].eevt, VEC[i].ec}, int'(VEC[i].req), i);
        end

        // R11 reset clears active alerts
        do_reset();
        check(6'b0, 11, 100);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 gap larger than limit: release level saturates at zero
        gp = 200;
        drive(0, 0, 1, 0, 150, 10, 100);
        drive(0, 0, 1, 0, 150, 10, 100);
        drive(0, 0, 1, 0, 150, 10, 100);
        check(6'b100101, 5, 101);
        drive(0, 0, 1, 0, 0, 10, 100);
        check(6'b100000, 5, 102);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R11 got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule